// File: doc/BRIEF.md
# UTF-8 Code Point Serializer

This block turns Unicode scalar values into their UTF-8 byte sequences. A code point arrives on a valid/ready input. The block picks the shortest legal UTF-8 form for that value: one, two, three or four bytes. It spreads the value's payload bits over the marker bits of that form and sends the bytes one per cycle on a byte-wide valid/ready output. The lead byte goes out first, and the final byte of each sequence is flagged. Values that cannot be encoded raise a one-cycle error pulse. Such values are taken from the input but send nothing.

Back-pressure rules work as follows. An input transfer takes place on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` drops in the cycle after a valid code point is taken. It stays low until the final byte of that sequence has been taken, so the code point is held inside the block for the whole sequence. An output transfer takes place on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the byte and its last flag do not change. Once `out_valid` is high it stays high until that byte has been taken. Parameter `FOUR_BYTE_EN` (default 1) enables the four-byte form. When it is 0, every value above 0xFFFF is treated as an error.

Top module: `utf8_encoder`

## Requirements
- R1: A code point from 0x00 to 0x7F produces exactly one byte equal to the value, with `out_last` high.
- R2: A code point from 0x80 to 0x7FF produces two bytes. The first is 110 followed by bits 10..6, and the second is 10 followed by bits 5..0. For example, 0x7FF gives 0xDF 0xBF and 0x7EB gives 0xDF 0xAB. The first byte always lies in 0xC2..0xDF.
- R3: A code point from 0x800 to 0xFFFF, other than a surrogate, produces three bytes: 1110 followed by bits 15..12, then 10 followed by bits 11..6, then 10 followed by bits 5..0.
- R4: A code point from 0x10000 to 0x10FFFF produces four bytes: 11110 followed by bits 20..18, then three bytes of 10 followed by bits 17..12, 11..6 and 5..0.
- R5: A code point from 0xD800 to 0xDFFF, or above 0x10FFFF, is taken from the input. `err_pulse` is high for exactly the one cycle after it is taken, and no byte is sent.
- R6: `in_ready` is low from the cycle after a valid code point is taken until the final byte of its sequence has been taken. Otherwise it is high.
- R7: `out_last` is high only on the final byte of a sequence. After the final byte is taken, `out_valid` is low in the next cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_last` hold their values into the next cycle.
- R9: Every byte of a sequence other than the first has the form 10xxxxxx, in the range 0x80..0xBF.
- R10: While reset is held, `out_valid` and `err_pulse` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all transfers happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A code point is offered |
| in_ready | output | 1 | The block can take a code point |
| in_cp | input | 21 | Code point value |
| out_valid | output | 1 | `out_byte` holds a byte to send |
| out_ready | input | 1 | The downstream side takes the byte |
| out_byte | output | 8 | Encoded byte |
| out_last | output | 1 | Marks the final byte of a sequence |
| err_pulse | output | 1 | One-cycle pulse for a value that cannot be encoded |

## Verification
The assertions check on every cycle the properties that hold whatever the stimulus:
- the held byte under back-pressure;
- the continuation-byte form and the lead-byte range of the two-byte form;
- the marker bits of the four-byte form;
- the single-byte pass-through;
- the error pulse together with the absence of output;
- `in_ready` dropping once a sequence starts.

Only the bench scenarios can show complete byte sequences. The bench compares them against an independent reference on the range edges (0x7F/0x80, 0x7FF/0x800, the surrogate edges, 0xFFFF/0x10000, 0x10FFFF/0x110000) and on random values under random stalls. It also confirms that the end of each sequence releases the input.

// File: rtl/utf8_enc_pkg.sv
package utf8_enc_pkg;
  localparam int CP_W     = 21;
  localparam int BYTE_W   = 8;
  localparam int MAX_BYTES = 4;
  localparam int IDX_W    = $clog2(MAX_BYTES);
  localparam int PAY_W    = 6;
  localparam logic [CP_W-1:0] LIMIT_1B  = 21'h00007F;
  localparam logic [CP_W-1:0] LIMIT_2B  = 21'h0007FF;
  localparam logic [CP_W-1:0] LIMIT_3B  = 21'h00FFFF;
  localparam logic [CP_W-1:0] LIMIT_4B  = 21'h10FFFF;
  localparam logic [CP_W-1:0] SURR_LO   = 21'h00D800;
  localparam logic [CP_W-1:0] SURR_HI   = 21'h00DFFF;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [MAX_BYTES-1:0] seq_t;

  // encoded as byte count minus one
  typedef enum logic [IDX_W-1:0] {
    SEQ_1 = 2'd0,
    SEQ_2 = 2'd1,
    SEQ_3 = 2'd2,
    SEQ_4 = 2'd3
  } seq_len_e;
endpackage

// File: rtl/utf8_classify.sv
module utf8_classify
  import utf8_enc_pkg::*;
#(
  parameter bit FOUR_BYTE_EN = 1'b1
) (
  input  logic [CP_W-1:0] cp,
  output seq_len_e        len,
  output logic            bad
);
  logic surrogate;
  logic too_big;

  assign surrogate = (cp >= SURR_LO) && (cp <= SURR_HI);

  generate
    if (FOUR_BYTE_EN) begin : g_four
      assign too_big = (cp > LIMIT_4B);
    end else begin : g_three
      assign too_big = (cp > LIMIT_3B);
    end
  endgenerate

  assign bad = surrogate || too_big;

  always_comb begin
    if (cp <= LIMIT_1B)      len = SEQ_1;
    else if (cp <= LIMIT_2B) len = SEQ_2;
    else if (cp <= LIMIT_3B) len = SEQ_3;
    else                     len = SEQ_4;
  end
endmodule

// File: rtl/utf8_pack.sv
module utf8_pack
  import utf8_enc_pkg::*;
(
  input  logic [CP_W-1:0] cp,
  input  seq_len_e        len,
  output seq_t            bytes
);
  localparam int EXT_W = MAX_BYTES * PAY_W;

  logic [EXT_W-1:0] cp_ext;
  byte_t            cont [MAX_BYTES];
  byte_t            lead;

  assign cp_ext = {{(EXT_W-CP_W){1'b0}}, cp};

  // cont[j] carries the j-th six-bit group counted from the least significant end
  generate
    for (genvar j = 0; j < MAX_BYTES; j++) begin : g_cont
      assign cont[j] = {2'b10, cp_ext[j*PAY_W +: PAY_W]};
    end
  endgenerate

  always_comb begin
    unique case (len)
      SEQ_1:   lead = {1'b0, cp[6:0]};
      SEQ_2:   lead = {3'b110, cp[10:6]};
      SEQ_3:   lead = {4'b1110, cp[15:12]};
      default: lead = {5'b11110, cp[20:18]};
    endcase
  end

  generate
    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_slot
      if (i == 0) begin : g_lead
        assign bytes[i] = lead;
      end else begin : g_tail
        logic [IDX_W-1:0] sel;
        assign sel = IDX_W'(int'(len) - i);
        assign bytes[i] = (int'(len) >= i) ? cont[sel] : '0;
      end
    end
  endgenerate
endmodule

// File: rtl/utf8_serializer.sv
module utf8_serializer
  import utf8_enc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  seq_t     load_bytes,
  input  seq_len_e load_len,
  output logic     busy,
  output logic     out_valid,
  input  logic     out_ready,
  output byte_t    out_byte,
  output logic     out_last
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] end_q;
  seq_t             buf_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      end_q  <= '0;
      buf_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      end_q  <= load_len;
      buf_q  <= load_bytes;
    end else if (busy_q && out_ready) begin
      if (idx_q == end_q) busy_q <= 1'b0;
      else                idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign out_byte  = buf_q[idx_q];
  assign out_last  = busy_q && (idx_q == end_q);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));

  p_cont_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (idx_q != '0) |-> out_byte[7:6] == 2'b10);

  p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  p_lead2_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (idx_q == '0) && (end_q == 2'd1) |-> out_byte >= 8'hC2 && out_byte <= 8'hDF);
endmodule

// File: rtl/utf8_encoder.sv
module utf8_encoder
  import utf8_enc_pkg::*;
#(
  parameter bit FOUR_BYTE_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CP_W-1:0] in_cp,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_byte,
  output logic            out_last,
  output logic            err_pulse
);
  seq_len_e len;
  logic     bad;
  seq_t     bytes;
  logic     busy;
  logic     accept;
  logic     load;
  logic     err_q;

  utf8_classify #(.FOUR_BYTE_EN(FOUR_BYTE_EN)) u_classify (
    .cp  (in_cp),
    .len (len),
    .bad (bad)
  );

  utf8_pack u_pack (
    .cp    (in_cp),
    .len   (len),
    .bytes (bytes)
  );

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign load     = accept && !bad;

  utf8_serializer u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_bytes (bytes),
    .load_len   (len),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_byte   (out_byte),
    .out_last   (out_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= accept && bad;
  end

  assign err_pulse = err_q;

  p_single_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_cp <= LIMIT_1B) |=>
      out_valid && out_last && out_byte == {1'b0, $past(in_cp[6:0])});

  p_bad_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ((in_cp >= SURR_LO && in_cp <= SURR_HI) || in_cp > LIMIT_4B) |=>
      err_pulse && !out_valid);

  p_ready_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !((in_cp >= SURR_LO && in_cp <= SURR_HI) || in_cp > LIMIT_4B) |=>
      !in_ready && out_valid);

  p_lead4_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && FOUR_BYTE_EN && in_cp > LIMIT_3B && in_cp <= LIMIT_4B |=>
      out_byte[7:3] == 5'b11110);

  p_no_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !out_valid);
endmodule

// File: tb/utf8_encoder_tb.sv
module utf8_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [20:0] in_cp;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_byte;
  logic        out_last;
  logic        err_pulse;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  utf8_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cp(in_cp), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last), .err_pulse(err_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference: byte k of the sequence in bits [31-8k -: 8]
  function automatic void ref_enc(input int cp, output logic [31:0] seq,
                                  output int n, output bit bad);
    bad = 0; seq = '0; n = 0;
    if ((cp >= 'hD800 && cp <= 'hDFFF) || cp > 'h10FFFF) bad = 1;
    else if (cp < 'h80) begin
      n = 1; seq[31:24] = cp[7:0];
    end else if (cp < 'h800) begin
      n = 2;
      seq[31:24] = 8'hC0 | 8'(cp >> 6);
      seq[23:16] = 8'h80 | 8'(cp & 'h3F);
    end else if (cp < 'h10000) begin
      n = 3;
      seq[31:24] = 8'hE0 | 8'(cp >> 12);
      seq[23:16] = 8'h80 | 8'((cp >> 6) & 'h3F);
      seq[15:8]  = 8'h80 | 8'(cp & 'h3F);
    end else begin
      n = 4;
      seq[31:24] = 8'hF0 | 8'(cp >> 18);
      seq[23:16] = 8'h80 | 8'((cp >> 12) & 'h3F);
      seq[15:8]  = 8'h80 | 8'((cp >> 6) & 'h3F);
      seq[7:0]   = 8'h80 | 8'(cp & 'h3F);
    end
  endfunction

  function automatic string tag_of(input int n, input bit bad);
    if (bad) return "R5";
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic run_cp(input int cp, input int max_stall);
    logic [31:0] seq;
    int n;
    bit bad;
    string t;
    ref_enc(cp, seq, n, bad);
    t = tag_of(n, bad);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_cp = 21'(cp);
    @(negedge clk);
    in_valid = 1'b0;
    if (bad) begin
      chk(err_pulse == 1'b1, "R5 err pulse", err_pulse, 1);
      chk(out_valid == 1'b0, "R5 no output", out_valid, 0);
      @(negedge clk);
      chk(err_pulse == 1'b0 && out_valid == 1'b0, "R5 single pulse",
          {err_pulse, out_valid}, 0);
    end else begin
      for (int i = 0; i < n; i++) begin
        int stall;
        logic [7:0] eb;
        eb = seq[31-8*i -: 8];
        stall = (max_stall == 0) ? 0 : int'($urandom % (max_stall + 1));
        for (int s = 0; s < stall; s++) begin
          out_ready = 1'b0;
          chk(out_valid && out_byte == eb && out_last == (i == n - 1),
              "R8 hold", {out_valid, out_byte}, {1'b1, eb});
          @(negedge clk);
        end
        chk(out_valid == 1'b1 && out_byte == eb, {t, " byte"},
            {out_valid, out_byte}, {1'b1, eb});
        chk(out_last == (i == n - 1), "R7 last flag", out_last, int'(i == n - 1));
        chk(in_ready == 1'b0, "R6 ready low", in_ready, 0);
        if (i > 0) chk(out_byte[7:6] == 2'b10, "R9 cont form", out_byte, 'h80);
        if (n == 2 && i == 0)
          chk(out_byte >= 8'hC2 && out_byte <= 8'hDF, "R2 lead range", out_byte, 'hC2);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
      end
      chk(out_valid == 1'b0, "R7 ends", out_valid, 0);
      chk(in_ready == 1'b1, "R6 ready back", in_ready, 1);
    end
  endtask

  function automatic int rand_cp();
    int k;
    k = int'($urandom % 5);
    case (k)
      0: return int'($urandom % 'h80);
      1: return 'h80 + int'($urandom % 'h780);
      2: begin
        int v;
        v = 'h800 + int'($urandom % 'hF800);
        return v;
      end
      3: return 'h10000 + int'($urandom % 'h100000);
      default: return ($urandom % 2) ? ('hD800 + int'($urandom % 'h800))
                                     : ('h110000 + int'($urandom % 'hF0000));
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int directed [15] = '{'h00, 'h7F, 'h80, 'h7FF, 'h7EB, 'h800, 'hD7FF, 'hD800,
                          'hDFFF, 'hE000, 'hFFFF, 'h10000, 'h10FFFF, 'h110000, 'h1FFFFF};
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_cp = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && err_pulse == 1'b0, "R10 outputs idle",
        {out_valid, err_pulse}, 0);
    chk(in_ready == 1'b1, "R10 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R10 after reset",
        {in_ready, out_valid}, 2);
    foreach (directed[i]) run_cp(directed[i], 0);
    foreach (directed[i]) run_cp(directed[i], 3);
    for (int k = 0; k < 400; k++) run_cp(rand_cp(), 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule